// File: doc/BRIEF.md
# Tiled Sprite Bitmap Address Generator

This block walks a sprite's screen area in raster order and, for every sprite pixel, emits the memory address of the bitmap texel that should be drawn there. The bitmap is described by a per-image record: its width and height, a horizontal and a vertical scroll offset, and a 24-bit origin address. Texels are 16-bit (RGB555), so each one occupies two bytes.

A sprite can be larger than its bitmap. In that case the bitmap coordinates wrap in both axes and the image repeats as tiles over the sprite. Changing the scroll offsets slides the bitmap content inside the fixed sprite rectangle. Both wraps are done with compare-and-subtract counters, not dividers, so any bitmap size is accepted.

A renderer pulses `start` with the sprite size and the image record. The block then streams one address per sprite pixel over a valid/ready interface. It marks the final pixel with a last flag and pulses `done` once the stream is complete.

Top module: `sprite_tile_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `done` and `busy` are all low.
- R2: Each emitted address equals (origin + 2 * (by * bmp_w + bx)) modulo 2^24.
- R3: A job emits exactly spr_w * spr_h addresses. They come row by row from sy = 0, and left to right from sx = 0 within a row. `addr_valid` is never high while `busy` is low.
- R4: The bitmap column is bx = (sx + xoff) mod bmp_w and the bitmap row is by = (sy + yoff) mod bmp_h. This makes the bitmap tile a larger sprite in both axes.
- R5: Scroll offsets may be larger than the bitmap size. They are first reduced modulo the size, one subtraction per cycle, before the first address appears.
- R6: `addr_last` is high on the address for sx = spr_w-1, sy = spr_h-1 and on no other address.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr_valid`, `addr` and `addr_last` hold their values into the next cycle.
- R8: `busy` is high from the cycle after an accepted start. `done` pulses for one cycle, in the cycle after the handshake of the last address, and `busy` is low in that cycle.
- R9: If spr_w, spr_h, bmp_w or bmp_h is zero, no address is emitted. `done` pulses in the cycle after `start`, and `busy` stays low.
- R10: A `start` pulse while `busy` is high is ignored. The running job's address stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; taken only when idle |
| spr_w | input | 9 | Sprite width in pixels |
| spr_h | input | 9 | Sprite height in pixels |
| bmp_w | input | 9 | Bitmap width in texels |
| bmp_h | input | 9 | Bitmap height in texels |
| bmp_xoff | input | 8 | Horizontal scroll offset inside the bitmap |
| bmp_yoff | input | 8 | Vertical scroll offset inside the bitmap |
| bmp_origin | input | 24 | Byte address of bitmap texel (0,0) |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | An address is presented |
| addr | output | 24 | Texel byte address |
| addr_last | output | 1 | Final pixel of the sprite |
| done | output | 1 | One-cycle job completion pulse |
| busy | output | 1 | A job is in progress |

## Verification
The hard case is a cycle in which the end of a sprite row coincides with a bitmap column wrap, and sometimes also with a bitmap row wrap. The horizontal counter must then rewind to its scrolled home position instead of wrapping to zero, while the vertical counter steps. The bench sweeps sprite sizes that are exact multiples of the bitmap size, sizes that are not, and offsets below and above the bitmap size. Every address is compared with a modulo formula computed independently in the bench, under irregular backpressure, so these coincidences occur both with and without stalls.

// File: rtl/sta_pkg.sv
package sta_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2
  } sta_state_e;

  // log2 of bytes per texel (16-bit colour)
  localparam int PIX_SHIFT = 1;
endpackage

// File: rtl/sta_wrap_ctr.sv
module sta_wrap_ctr #(
  parameter int POS_W = 9,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] load_val,
  input  logic             reduce,
  input  logic             rewind,
  input  logic             step,
  input  logic [POS_W-1:0] size,
  input  logic             chk_en,
  output logic [POS_W-1:0] pos,
  output logic             settled,
  output logic             wrap
);
  logic [POS_W-1:0] home;
  logic [POS_W:0]   pos_inc;

  assign pos_inc = {1'b0, pos} + (POS_W+1)'(1);
  assign settled = (home < size);
  assign wrap    = step && (pos_inc == {1'b0, size});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      home <= '0;
      pos  <= '0;
    end else if (load) begin
      home <= POS_W'(load_val);
      pos  <= POS_W'(load_val);
    end else if (reduce) begin
      if (!settled) begin
        home <= home - size;
        pos  <= home - size;
      end else begin
        pos  <= home;
      end
    end else if (rewind) begin
      pos <= home;
    end else if (step) begin
      pos <= wrap ? '0 : pos_inc[POS_W-1:0];
    end
  end

  // R4: once scanning, the bitmap coordinate stays inside the bitmap
  assert_pos_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (pos < size));

  // R5: each reduction cycle strictly lowers the home position
  assert_reduce_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reduce && !load && !settled && size != '0) |=> (home < $past(home)));
endmodule

// File: rtl/sta_raster_ctr.sv
module sta_raster_ctr #(
  parameter int DIM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [DIM_W-1:0] w,
  input  logic [DIM_W-1:0] h,
  output logic [DIM_W-1:0] sx,
  output logic [DIM_W-1:0] sy,
  output logic             row_end,
  output logic             frame_end
);
  assign row_end   = (sx == w - DIM_W'(1));
  assign frame_end = row_end && (sy == h - DIM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sx <= '0;
      sy <= '0;
    end else if (clear) begin
      sx <= '0;
      sy <= '0;
    end else if (step) begin
      if (row_end) begin
        sx <= '0;
        sy <= sy + DIM_W'(1);
      end else begin
        sx <= sx + DIM_W'(1);
      end
    end
  end

  // R3: the row index never passes the sprite height while stepping
  assert_row_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !frame_end && h != '0) |=> (sy < h));
endmodule

// File: rtl/sta_addr_calc.sv
module sta_addr_calc #(
  parameter int POS_W  = 9,
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] origin,
  input  logic [POS_W-1:0]  bw,
  input  logic [POS_W-1:0]  bx,
  input  logic [POS_W-1:0]  by,
  output logic [ADDR_W-1:0] addr
);
  import sta_pkg::*;

  function automatic logic [ADDR_W-1:0] texel_addr(
    input logic [ADDR_W-1:0] org,
    input logic [POS_W-1:0]  width,
    input logic [POS_W-1:0]  col,
    input logic [POS_W-1:0]  row
  );
    logic [ADDR_W-1:0] idx;
    idx = ADDR_W'(row) * ADDR_W'(width) + ADDR_W'(col);
    return org + (idx << PIX_SHIFT);
  endfunction

  assign addr = texel_addr(origin, bw, bx, by);
endmodule

// File: rtl/sprite_tile_addr_gen.sv
module sprite_tile_addr_gen #(
  parameter int SPR_DW = 9,
  parameter int BMP_DW = 9,
  parameter int OFF_W  = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SPR_DW-1:0] spr_w,
  input  logic [SPR_DW-1:0] spr_h,
  input  logic [BMP_DW-1:0] bmp_w,
  input  logic [BMP_DW-1:0] bmp_h,
  input  logic [OFF_W-1:0]  bmp_xoff,
  input  logic [OFF_W-1:0]  bmp_yoff,
  input  logic [ADDR_W-1:0] bmp_origin,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_last,
  output logic              done,
  output logic              busy
);
  import sta_pkg::*;

  sta_state_e        state;
  logic [SPR_DW-1:0] sw_q, sh_q;
  logic [BMP_DW-1:0] bw_q, bh_q;
  logic [ADDR_W-1:0] org_q;
  logic              done_q;

  // named internal events
  logic              accept, zero_job, in_prep, in_run, fire;
  logic              prep_done, row_end, frame_end;
  logic              x_settled, y_settled, x_wrap, y_wrap;
  logic [SPR_DW-1:0] sx, sy;
  logic [BMP_DW-1:0] bx, by;

  assign zero_job  = (spr_w == '0) || (spr_h == '0) ||
                     (bmp_w == '0) || (bmp_h == '0);
  assign accept    = start && (state == ST_IDLE);
  assign in_prep   = (state == ST_PREP);
  assign in_run    = (state == ST_RUN);
  assign fire      = in_run && addr_ready;
  assign prep_done = in_prep && x_settled && y_settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sw_q   <= '0;
      sh_q   <= '0;
      bw_q   <= '0;
      bh_q   <= '0;
      org_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (zero_job) begin
            done_q <= 1'b1;
          end else begin
            sw_q  <= spr_w;
            sh_q  <= spr_h;
            bw_q  <= bmp_w;
            bh_q  <= bmp_h;
            org_q <= bmp_origin;
            state <= ST_PREP;
          end
        end
        ST_PREP: if (prep_done) state <= ST_RUN;
        ST_RUN: if (fire && frame_end) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  sta_raster_ctr #(.DIM_W(SPR_DW)) u_raster (
    .clk(clk), .rst_n(rst_n),
    .clear(accept), .step(fire),
    .w(sw_q), .h(sh_q),
    .sx(sx), .sy(sy),
    .row_end(row_end), .frame_end(frame_end)
  );

  sta_wrap_ctr #(.POS_W(BMP_DW), .OFF_W(OFF_W)) u_wrap_x (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_val(bmp_xoff),
    .reduce(in_prep), .rewind(fire && row_end), .step(fire),
    .size(bw_q), .chk_en(in_run),
    .pos(bx), .settled(x_settled), .wrap(x_wrap)
  );

  sta_wrap_ctr #(.POS_W(BMP_DW), .OFF_W(OFF_W)) u_wrap_y (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_val(bmp_yoff),
    .reduce(in_prep), .rewind(1'b0), .step(fire && row_end),
    .size(bh_q), .chk_en(in_run),
    .pos(by), .settled(y_settled), .wrap(y_wrap)
  );

  sta_addr_calc #(.POS_W(BMP_DW), .ADDR_W(ADDR_W)) u_calc (
    .origin(org_q), .bw(bw_q), .bx(bx), .by(by), .addr(addr)
  );

  assign addr_valid = in_run;
  assign addr_last  = in_run && frame_end;
  assign done       = done_q;
  assign busy       = (state != ST_IDLE);

  // R3: nothing is offered while idle
  assert_no_valid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !addr_valid);

  // R7: a stalled beat keeps its content
  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr) && $stable(addr_last)));

  // R8: final handshake is followed by the done pulse and idle
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && addr_last) |=> (done && !busy));

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: degenerate job completes at once without becoming busy
  assert_zero_job_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && zero_job) |=> (done && !busy && !addr_valid));

  // R10: a start during a job does not end it early
  assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(addr_valid && addr_ready && addr_last)) |=> busy);

  // R4: a column wrap inside a row only happens while scanning
  assert_wrap_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (x_wrap || y_wrap) |-> in_run);
endmodule

// File: tb/sprite_tile_addr_gen_bench.sv
`timescale 1ns/1ps
module sprite_tile_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  spr_w = '0, spr_h = '0, bmp_w = '0, bmp_h = '0;
  logic [7:0]  bmp_xoff = '0, bmp_yoff = '0;
  logic [23:0] bmp_origin = '0;
  logic        addr_ready = 1'b0;
  logic        addr_valid, addr_last, done, busy;
  logic [23:0] addr;

  int checks = 0;
  int errors = 0;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  sprite_tile_addr_gen u_sprite_tile_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .spr_w(spr_w), .spr_h(spr_h), .bmp_w(bmp_w), .bmp_h(bmp_h),
    .bmp_xoff(bmp_xoff), .bmp_yoff(bmp_yoff), .bmp_origin(bmp_origin),
    .addr_ready(addr_ready), .addr_valid(addr_valid), .addr(addr),
    .addr_last(addr_last), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_addr(int k, int sw, int bw, int bh,
                                           int xo, int yo, logic [23:0] org);
    int sxe, sye, bxe, bye;
    sxe = k % sw;
    sye = k / sw;
    bxe = (sxe + xo) % bw;
    bye = (sye + yo) % bh;
    return 24'(org + 24'(2 * (bye * bw + bxe)));
  endfunction

  task automatic run_job(input int sw, input int sh, input int bw, input int bh,
                         input int xo, input int yo, input logic [23:0] org,
                         input bit poke);
    int total, k;
    bit held, pend, fin;
    logic [23:0] haddr, ea;
    logic hlast;
    @(negedge clk);
    spr_w = 9'(sw); spr_h = 9'(sh); bmp_w = 9'(bw); bmp_h = 9'(bh);
    bmp_xoff = 8'(xo); bmp_yoff = 8'(yo); bmp_origin = org;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    if (sw == 0 || sh == 0 || bw == 0 || bh == 0) begin
      check(done && !addr_valid && !busy, "R9 zero job done", {29'd0, done, addr_valid, busy}, 32'h4);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); #1;
        check(!addr_valid && !done && !busy, "R9 zero job quiet", {29'd0, done, addr_valid, busy}, 32'h0);
      end
      return;
    end
    check(busy && !done, "R8 busy after start", {30'd0, busy, done}, 32'h2);
    total = sw * sh; k = 0; held = 0; pend = 0; fin = 0;
    for (int c = 0; c < 4000 && !fin; c++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      addr_ready = lf[0] | lf[3];
      if (poke && c == 3) begin
        start = 1'b1; spr_w = 9'd2; spr_h = 9'd2; bmp_w = 9'd1; bmp_h = 9'd1;
        bmp_xoff = 8'd0; bmp_yoff = 8'd0; bmp_origin = 24'h000000;
      end else begin
        start = 1'b0;
      end
      #1;
      if (pend) begin
        check(done && !busy && !addr_valid, "R8 done after last", {30'd0, done, busy}, 32'h2);
        fin = 1;
      end else if (done) begin
        check(1'b0, "R8 early done", 32'(k), 32'(total));
      end
      if (held)
        check(addr_valid && addr == haddr && addr_last == hlast, "R7 hold on stall",
              {7'd0, addr_valid, addr}, {8'd1, haddr});
      held = 0;
      if (!fin && addr_valid) begin
        if (k >= total) begin
          check(1'b0, "R3 extra beat", 32'(k), 32'(total));
        end else if (addr_ready) begin
          ea = exp_addr(k, sw, bw, bh, xo, yo, org);
          check(addr == ea, "R2 R4 R5 address", {8'd0, addr}, {8'd0, ea});
          check(addr_last == (k == total - 1), "R6 last flag",
                {31'd0, addr_last}, {31'd0, (k == total - 1)});
          k++;
          if (k == total) pend = 1;
        end else begin
          held = 1; haddr = addr; hlast = addr_last;
        end
      end
    end
    if (!fin) check(1'b0, "R8 no done", 32'(k), 32'(total));
    check(k == total, "R3 beat count", 32'(k), 32'(total));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!addr_valid && !done && !busy, "R1 reset state",
          {29'd0, addr_valid, done, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!addr_valid && !done && !busy, "R1 after reset",
          {29'd0, addr_valid, done, busy}, 32'h0);

    // R4 R5 sweep: tiling and scrolling over a small space
    begin
      int bws[4] = '{1, 2, 3, 5};
      int bhs[3] = '{1, 2, 3};
      int sws[3] = '{1, 4, 6};
      int shs[2] = '{1, 5};
      int offs[3] = '{0, 2, 7};
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 3; b++)
          for (int c = 0; c < 3; c++)
            for (int d = 0; d < 2; d++)
              for (int e = 0; e < 3; e++)
                for (int f = 0; f < 3; f++)
                  run_job(sws[c], shs[d], bws[a], bhs[b], offs[e], offs[f],
                          24'(32'h1000 * (a + 1) + 32'h10 * e), 1'b0);
    end

    // R2: origin near the top of the address space wraps modulo 2^24
    run_job(6, 3, 4, 2, 1, 1, 24'hFFFFF8, 1'b0);
    // R5 R10: large offsets, long prep, start poked while busy
    run_job(20, 9, 4, 3, 255, 200, 24'hFFFFF0, 1'b1);
    // R4: full 256 texel bitmap with offsets at the top of the range
    run_job(3, 2, 256, 256, 254, 255, 24'h100000, 1'b0);
    // R9: degenerate sizes
    run_job(0, 4, 2, 2, 0, 0, 24'h0, 1'b0);
    run_job(4, 0, 2, 2, 0, 0, 24'h0, 1'b0);
    run_job(4, 4, 0, 2, 0, 0, 24'h0, 1'b0);
    run_job(4, 4, 2, 0, 0, 0, 24'h0, 1'b0);
    // normal job right after a degenerate one
    run_job(3, 3, 2, 2, 1, 0, 24'h000200, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule